// File: doc/BRIEF.md
# Two-Channel Weighted PWM Audio Converter

This block turns a stream of signed 16-bit audio samples into two single-bit pulse-width outputs. Outside the chip, a resistor network adds the two outputs with weights that differ by a factor of 256. The upper half of each sample sets the duty of a coarse output. The lower half sets the duty of a fine output. Both outputs are compared against one shared free-running period counter, so each PWM edge is placed to a single clock.

Samples enter through a valid/ready handshake backed by a one-entry holding register. One clock before the end of every second PWM period, the block pulses a request strobe and takes the next sample. The sample comes from the holding register, or straight from the input when that register is empty. If neither has a sample, silence is used and a sticky underrun flag is raised. The converted compare values go into a pending stage and reach the comparators only when the counter wraps to zero. A pulse is therefore never cut short in the middle of a period.

Top module: `pwm_audio_dac`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), the outputs are as follows. The coarse compare is 120 and the fine compare is 0. `pwm_coarse` is high for the first 120 clocks of the first period and `pwm_fine` stays low. `req_strobe` is low, `smp_ready` is high and `underrun_flag` is low.
- R2: The shared counter starts at 0 after reset, counts up to 543 and wraps to 0. Each PWM period is therefore 544 clocks, and `pwm_coarse` rises exactly once every 544 clocks.
- R3: Each PWM output is high in a clock exactly when the counter is below that channel's active compare value.
- R4: A sample is converted to offset binary by inverting bit 15. The coarse compare is bits 15:8 of the result plus 120, so it lies in 120..375 and is never 0. The fine compare is bits 7:0 of the result, in 0..255.
- R5: `req_strobe` is high for exactly one clock in every 1088. That clock is at counter value 542 of every second period, which is clock index 1086 modulo 1088, counted from the first edge after reset.
- R6: Compare values taken at a strobe become active when the counter next wraps to 0. They then stay unchanged for two whole periods.
- R7: `smp_ready` is high when the holding register is empty, and it is also high in a strobe clock. A sample accepted outside a strobe is stored and used at the next strobe. A sample presented at a strobe while the register is empty is used directly. A sample presented at a strobe while the register is full replaces the stored sample after the stored one is used.
- R8: If a strobe finds no stored sample and no valid input, the next two periods use the silence code: coarse compare 248 and fine compare 0. `underrun_flag` is also set.
- R9: `underrun_flag` stays set until `underrun_clr` is high at a clock edge. If an underrun and a clear occur in the same clock, the flag stays set.
- R10: Reset applied in the middle of operation drops any stored sample and clears the flag. It also restarts the counter and returns both compares to 120 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 1 | Sample offered |
| smp_data | input | 16 | Signed sample |
| smp_ready | output | 1 | Sample can be taken this clock |
| underrun_clr | input | 1 | Clears the underrun flag |
| req_strobe | output | 1 | One-clock sample request, every second period |
| underrun_flag | output | 1 | Sticky: a strobe found no sample |
| pwm_coarse | output | 1 | Coarse-weight PWM output |
| pwm_fine | output | 1 | Fine-weight PWM output |

## Verification
Two pairs of events can fall in the same clock. The first pair is an underrun at a strobe and a flag clear: the bench drives `underrun_clr` in the strobe clock with no data offered, and expects the flag to stay set. The second pair is a sample handoff at a strobe and a new sample arriving. The bench presents a sample in the strobe clock once with the holding register full and once with it empty. A behavioural model then predicts which sample's duty appears, and when, through the outputs of every clock.

// File: rtl/pwm_dac_pkg.sv
package pwm_dac_pkg;
   localparam int NUM_CH    = 2;
   localparam int CH_COARSE = 0;
   localparam int CH_FINE   = 1;

   typedef enum logic [1:0] {
      FEED_HOLD    = 2'd0,
      FEED_BYPASS  = 2'd1,
      FEED_SILENCE = 2'd2
   } feed_src_e;
endpackage

// File: rtl/pwm_period_timer.sv
module pwm_period_timer #(
   parameter int PERIOD       = 544,
   parameter int HOLD_PERIODS = 2,
   parameter int CNT_W        = $clog2(PERIOD)
) (
   input  logic             clk,
   input  logic             rst,
   output logic [CNT_W-1:0] count,
   output logic             wrap,
   output logic             strobe
);
   localparam int PH_W = (HOLD_PERIODS > 1) ? $clog2(HOLD_PERIODS) : 1;

   logic [CNT_W-1:0] cnt_q;
   logic             last_period;

   assign count = cnt_q;
   assign wrap  = (cnt_q == CNT_W'(PERIOD - 1));

   always_ff @(posedge clk) begin
      if (rst)       cnt_q <= '0;
      else if (wrap) cnt_q <= '0;
      else           cnt_q <= cnt_q + 1'b1;
   end

   generate
      if (HOLD_PERIODS > 1) begin : g_multi
         logic [PH_W-1:0] ph_q;
         assign last_period = (ph_q == PH_W'(HOLD_PERIODS - 1));
         always_ff @(posedge clk) begin
            if (rst)
               ph_q <= '0;
            else if (wrap)
               ph_q <= last_period ? '0 : ph_q + 1'b1;
         end
      end else begin : g_single
         assign last_period = 1'b1;
      end
   endgenerate

   assign strobe = last_period && (cnt_q == CNT_W'(PERIOD - 2));
endmodule

// File: rtl/pwm_sample_feed.sv
module pwm_sample_feed
   import pwm_dac_pkg::*;
#(
   parameter int SAMPLE_W = 16
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                strobe,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_data,
   output logic                in_ready,
   input  logic                flag_clr,
   output logic [SAMPLE_W-1:0] out_sample,
   output logic                out_silent,
   output logic                flag
);
   logic                full_q;
   logic [SAMPLE_W-1:0] hold_q;
   logic                flag_q;
   logic                accept;
   logic                underrun;
   feed_src_e           src;

   assign in_ready = !full_q || strobe;
   assign accept   = in_valid && in_ready;

   always_comb begin
      if (full_q)        src = FEED_HOLD;
      else if (in_valid) src = FEED_BYPASS;
      else               src = FEED_SILENCE;
   end

   always_comb begin
      case (src)
         FEED_HOLD:   out_sample = hold_q;
         FEED_BYPASS: out_sample = in_data;
         default:     out_sample = '0;
      endcase
   end

   assign out_silent = (src == FEED_SILENCE);
   assign underrun   = strobe && out_silent;

   always_ff @(posedge clk) begin
      if (rst) begin
         full_q <= 1'b0;
         hold_q <= '0;
      end else if (strobe) begin
         full_q <= full_q && accept;
         if (full_q && accept) hold_q <= in_data;
      end else if (accept) begin
         full_q <= 1'b1;
         hold_q <= in_data;
      end
   end

   always_ff @(posedge clk) begin
      if (rst)           flag_q <= 1'b0;
      else if (underrun) flag_q <= 1'b1;
      else if (flag_clr) flag_q <= 1'b0;
   end

   assign flag = flag_q;
endmodule

// File: rtl/pwm_cmp_bank.sv
module pwm_cmp_bank
   import pwm_dac_pkg::*;
#(
   parameter int SAMPLE_W       = 16,
   parameter int CMP_W          = 10,
   parameter int COARSE_BASE    = 120,
   parameter int SILENCE_COARSE = 248,
   parameter int SILENCE_FINE   = 0,
   parameter bit SIGNED_INPUT   = 1'b1
) (
   input  logic                           clk,
   input  logic                           rst,
   input  logic                           strobe,
   input  logic                           wrap,
   input  logic [SAMPLE_W-1:0]            sample,
   input  logic                           silent,
   output logic [NUM_CH-1:0][CMP_W-1:0]   cmp
);
   localparam int HALF_W = SAMPLE_W / 2;

   logic [SAMPLE_W-1:0]          ob;
   logic [NUM_CH-1:0][CMP_W-1:0] conv;
   logic [NUM_CH-1:0][CMP_W-1:0] idle;
   logic [NUM_CH-1:0][CMP_W-1:0] pend_q;
   logic [NUM_CH-1:0][CMP_W-1:0] act_q;

   generate
      if (SIGNED_INPUT) begin : g_signed
         assign ob = {~sample[SAMPLE_W-1], sample[SAMPLE_W-2:0]};
      end else begin : g_unsigned
         assign ob = sample;
      end
   endgenerate

   always_comb begin
      idle[CH_COARSE] = CMP_W'(COARSE_BASE);
      idle[CH_FINE]   = '0;
      if (silent) begin
         conv[CH_COARSE] = CMP_W'(SILENCE_COARSE);
         conv[CH_FINE]   = CMP_W'(SILENCE_FINE);
      end else begin
         conv[CH_COARSE] = CMP_W'(ob[SAMPLE_W-1 -: HALF_W]) + CMP_W'(COARSE_BASE);
         conv[CH_FINE]   = CMP_W'(ob[HALF_W-1:0]);
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= idle;
         act_q  <= idle;
      end else begin
         if (strobe) pend_q <= conv;
         if (wrap)   act_q  <= pend_q;
      end
   end

   assign cmp = act_q;
endmodule

// File: rtl/pwm_compare_out.sv
module pwm_compare_out
   import pwm_dac_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic [CNT_W-1:0]             count,
   input  logic [NUM_CH-1:0][CNT_W-1:0] cmp,
   output logic [NUM_CH-1:0]            pwm
);
   generate
      for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
         assign pwm[ch] = (count < cmp[ch]);
      end
   endgenerate
endmodule

// File: rtl/pwm_audio_dac.sv
module pwm_audio_dac
   import pwm_dac_pkg::*;
#(
   parameter int SAMPLE_W       = 16,
   parameter int PERIOD         = 544,
   parameter int HOLD_PERIODS   = 2,
   parameter int COARSE_BASE    = 120,
   parameter int SILENCE_COARSE = 248,
   parameter int SILENCE_FINE   = 0,
   parameter bit SIGNED_INPUT   = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   output logic                smp_ready,
   input  logic                underrun_clr,
   output logic                req_strobe,
   output logic                underrun_flag,
   output logic                pwm_coarse,
   output logic                pwm_fine
);
   localparam int HALF_W = SAMPLE_W / 2;
   localparam int CNT_W  = $clog2(PERIOD);

   generate
      if (SAMPLE_W % 2 != 0 || SAMPLE_W < 4) begin : g_bad_width
         $error("SAMPLE_W must be even and at least 4");
      end
      if (PERIOD < 4) begin : g_bad_period
         $error("PERIOD must be at least 4");
      end
      if (HOLD_PERIODS < 1) begin : g_bad_hold
         $error("HOLD_PERIODS must be at least 1");
      end
      if (COARSE_BASE < 1 || COARSE_BASE + (1 << HALF_W) - 1 >= PERIOD) begin : g_bad_base
         $error("coarse compare range must be nonzero and fit in a period");
      end
      if (SILENCE_COARSE >= PERIOD || SILENCE_FINE >= PERIOD) begin : g_bad_silence
         $error("silence code must fit in a period");
      end
   endgenerate

   logic [CNT_W-1:0]             count_w;
   logic                         wrap_w;
   logic                         strobe_w;
   logic [SAMPLE_W-1:0]          sample_w;
   logic                         silent_w;
   logic [NUM_CH-1:0][CNT_W-1:0] cmp_w;
   logic [NUM_CH-1:0]            pwm_w;

   pwm_period_timer #(
      .PERIOD       (PERIOD),
      .HOLD_PERIODS (HOLD_PERIODS),
      .CNT_W        (CNT_W)
   ) u_timer (
      .clk    (clk),
      .rst    (rst),
      .count  (count_w),
      .wrap   (wrap_w),
      .strobe (strobe_w)
   );

   pwm_sample_feed #(
      .SAMPLE_W (SAMPLE_W)
   ) u_feed (
      .clk        (clk),
      .rst        (rst),
      .strobe     (strobe_w),
      .in_valid   (smp_valid),
      .in_data    (smp_data),
      .in_ready   (smp_ready),
      .flag_clr   (underrun_clr),
      .out_sample (sample_w),
      .out_silent (silent_w),
      .flag       (underrun_flag)
   );

   pwm_cmp_bank #(
      .SAMPLE_W       (SAMPLE_W),
      .CMP_W          (CNT_W),
      .COARSE_BASE    (COARSE_BASE),
      .SILENCE_COARSE (SILENCE_COARSE),
      .SILENCE_FINE   (SILENCE_FINE),
      .SIGNED_INPUT   (SIGNED_INPUT)
   ) u_bank (
      .clk    (clk),
      .rst    (rst),
      .strobe (strobe_w),
      .wrap   (wrap_w),
      .sample (sample_w),
      .silent (silent_w),
      .cmp    (cmp_w)
   );

   pwm_compare_out #(
      .CNT_W (CNT_W)
   ) u_out (
      .count (count_w),
      .cmp   (cmp_w),
      .pwm   (pwm_w)
   );

   assign req_strobe = strobe_w;
   assign pwm_coarse = pwm_w[CH_COARSE];
   assign pwm_fine   = pwm_w[CH_FINE];
endmodule

// File: rtl/pwm_dac_checker.sv
module pwm_dac_checker #(
   parameter int CNT_W       = 10,
   parameter int PERIOD      = 544,
   parameter int COARSE_BASE = 120
) (
   input logic             clk,
   input logic             rst,
   input logic             req_strobe,
   input logic             smp_ready,
   input logic             underrun_flag,
   input logic             underrun_clr,
   input logic             wrap,
   input logic [CNT_W-1:0] count,
   input logic [CNT_W-1:0] cmp_coarse,
   input logic [CNT_W-1:0] cmp_fine
);
   assert_count_range_R2: assert property (@(posedge clk) disable iff (rst)
      count < CNT_W'(PERIOD));

   assert_coarse_floor_R4: assert property (@(posedge clk) disable iff (rst)
      cmp_coarse >= CNT_W'(COARSE_BASE));

   assert_strobe_pulse_R5: assert property (@(posedge clk) disable iff (rst)
      req_strobe |=> !req_strobe);

   assert_cmp_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !wrap |=> ($stable(cmp_coarse) && $stable(cmp_fine)));

   assert_ready_on_strobe_R7: assert property (@(posedge clk) disable iff (rst)
      req_strobe |-> smp_ready);

   assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (rst)
      (underrun_flag && !underrun_clr) |=> underrun_flag);

   assert_reset_idle_R10: assert property (@(posedge clk)
      rst |=> (cmp_coarse == CNT_W'(COARSE_BASE) && cmp_fine == '0 && !underrun_flag
               && count == '0));
endmodule

bind pwm_audio_dac pwm_dac_checker #(
   .CNT_W       (CNT_W),
   .PERIOD      (PERIOD),
   .COARSE_BASE (COARSE_BASE)
) u_checker (
   .clk           (clk),
   .rst           (rst),
   .req_strobe    (req_strobe),
   .smp_ready     (smp_ready),
   .underrun_flag (underrun_flag),
   .underrun_clr  (underrun_clr),
   .wrap          (wrap_w),
   .count         (count_w),
   .cmp_coarse    (cmp_w[pwm_dac_pkg::CH_COARSE]),
   .cmp_fine      (cmp_w[pwm_dac_pkg::CH_FINE])
);

// File: tb/pwm_audio_dac_bench.sv
module pwm_audio_dac_bench;
   localparam int CLK_PERIOD = 10;
   localparam int PER        = 544;
   localparam int PAIR       = 2 * PER;
   localparam int WATCHDOG   = 150000;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        smp_valid = 1'b0;
   logic [15:0] smp_data = '0;
   logic        underrun_clr = 1'b0;
   logic        smp_ready, req_strobe, underrun_flag, pwm_coarse, pwm_fine;

   int n_checks = 0;
   int n_fail   = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   pwm_audio_dac u_pwm_audio_dac (
      .clk           (clk),
      .rst           (rst),
      .smp_valid     (smp_valid),
      .smp_data      (smp_data),
      .smp_ready     (smp_ready),
      .underrun_clr  (underrun_clr),
      .req_strobe    (req_strobe),
      .underrun_flag (underrun_flag),
      .pwm_coarse    (pwm_coarse),
      .pwm_fine      (pwm_fine)
   );

   task automatic chk(input string tag, input int got, input int exp);
      n_checks++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d at %0t", tag, got, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int          t = 0;
   int          m_cc = 120, m_cf = 0, m_pc = 120, m_pf = 0;
   bit          m_flag = 0;
   logic [15:0] hold[$];

   function automatic int coarse_of(input logic [15:0] s);
      logic [15:0] ob = s ^ 16'h8000;
      return int'(ob[15:8]) + 120;
   endfunction

   function automatic int fine_of(input logic [15:0] s);
      logic [15:0] ob = s ^ 16'h8000;
      return int'(ob[7:0]);
   endfunction

   always @(posedge clk) begin
      if (rst) begin
         t = 0; hold.delete();
         m_cc = 120; m_cf = 0; m_pc = 120; m_pf = 0; m_flag = 0;
      end else begin
         bit st, wr, rdy, acc, was_empty, und;
         logic [15:0] s;
         st = (t % PAIR) == PAIR - 2;
         wr = (t % PER) == PER - 1;
         was_empty = (hold.size() == 0);
         rdy = was_empty || st;
         acc = smp_valid && rdy;
         und = 0;
         if (st) begin
            if (!was_empty) begin
               s = hold.pop_front(); m_pc = coarse_of(s); m_pf = fine_of(s);
            end else if (smp_valid) begin
               m_pc = coarse_of(smp_data); m_pf = fine_of(smp_data);
            end else begin
               m_pc = 248; m_pf = 0; und = 1;
            end
         end
         if (acc && !(st && was_empty)) hold.push_back(smp_data);
         if (wr) begin m_cc = m_pc; m_cf = m_pf; end
         if (und) m_flag = 1;
         else if (underrun_clr) m_flag = 0;
         t++;
      end
   end

   // per-clock comparison, away from the active edge
   int cyc = 0, last_rise = -1, last_strobe = -1;
   bit prev_c = 0;
   always @(negedge clk) begin
      bit exp_st;
      cyc++;
      exp_st = !rst && ((t % PAIR) == PAIR - 2);
      chk("R3 pwm_coarse", pwm_coarse, (t % PER) < m_cc);
      chk("R3 pwm_fine",   pwm_fine,   (t % PER) < m_cf);
      chk("R5 req_strobe", req_strobe, exp_st);
      chk("R7 smp_ready",  smp_ready,  (hold.size() == 0) || exp_st);
      chk("R9 underrun_flag", underrun_flag, m_flag);
      if (rst) begin
         last_rise = -1; last_strobe = -1;
      end else begin
         if (!prev_c && pwm_coarse) begin
            if (last_rise >= 0) chk("R2 rise spacing", cyc - last_rise, PER);
            last_rise = cyc;
         end
         if (req_strobe) begin
            if (last_strobe >= 0) chk("R5 strobe spacing", cyc - last_strobe, PAIR);
            last_strobe = cyc;
         end
      end
      prev_c = pwm_coarse;
   end

   // ---------------- stimulus helpers ----------------
   task automatic send(input logic [15:0] s);
      bit r;
      @(negedge clk);
      smp_valid = 1'b1; smp_data = s;
      forever begin
         r = smp_ready;
         @(negedge clk);
         if (r) break;
      end
      smp_valid = 1'b0;
   endtask

   task automatic wait_strobe();
      do @(negedge clk); while (!req_strobe);
   endtask

   // current negedge is a strobe clock: measure the two following periods
   task automatic measure_now(input int ec, input int ef, input string tag);
      @(negedge clk);
      for (int p = 0; p < 2; p++) begin
         int hc = 0, hf = 0;
         repeat (PER) begin
            @(negedge clk);
            hc += pwm_coarse; hf += pwm_fine;
         end
         chk(p == 0 ? {tag, " coarse duty"} : "R6 coarse held 2nd period", hc, ec);
         chk(p == 0 ? {tag, " fine duty"}   : "R6 fine held 2nd period",   hf, ef);
      end
   endtask

   task automatic measure_next(input int ec, input int ef, input string tag);
      wait_strobe();
      measure_now(ec, ef, tag);
   endtask

   task automatic first_period(input string tag);
      int hc, hf;
      hc = pwm_coarse; hf = pwm_fine;
      repeat (PER - 1) begin
         @(negedge clk);
         hc += pwm_coarse; hf += pwm_fine;
      end
      chk({tag, " idle coarse duty"}, hc, 120);
      chk({tag, " idle fine duty"}, hf, 0);
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   endtask

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected fewer", WATCHDOG);
      finish_run();
   end

   initial begin
      repeat (4) @(negedge clk);
      // R1: reset state
      chk("R1 pwm_coarse", pwm_coarse, 1);
      chk("R1 pwm_fine", pwm_fine, 0);
      chk("R1 smp_ready", smp_ready, 1);
      chk("R1 req_strobe", req_strobe, 0);
      chk("R1 underrun_flag", underrun_flag, 0);
      @(negedge clk);
      rst = 1'b0;
      first_period("R1");

      // R8: no data at the first strobe gives silence and sets the flag
      measure_next(248, 0, "R8");
      chk("R8 flag set", underrun_flag, 1);
      @(negedge clk); underrun_clr = 1'b1;
      @(negedge clk); underrun_clr = 1'b0;
      chk("R9 flag cleared", underrun_flag, 0);

      // R4: conversion across the range
      send(16'h0000); measure_next(248, 0,   "R4 zero");
      send(16'h7FFF); measure_next(375, 255, "R4 max");
      send(16'h8000); measure_next(120, 0,   "R4 min");
      send(16'h1234); measure_next(266, 52,  "R4 mid");
      send(16'hFFFF); measure_next(247, 255, "R4 minus one");

      // R7: second sample accepted at the strobe while the register is full
      send(16'h0100);
      send(16'h00FF);
      measure_next(248, 255, "R7 replaced hold");

      // R7: bypass, sample presented exactly at a strobe with the register empty
      wait_strobe();
      wait_strobe();
      smp_valid = 1'b1; smp_data = 16'h4000;
      @(negedge clk);
      smp_valid = 1'b0;
      repeat (PER) @(negedge clk);
      begin
         int hc = 0, hf = 0;
         repeat (PER) begin
            @(negedge clk);
            hc += pwm_coarse; hf += pwm_fine;
         end
         chk("R7 bypass coarse duty", hc, 312);
         chk("R7 bypass fine duty", hf, 0);
      end

      // R9: clear coinciding with an underrun keeps the flag set
      wait_strobe();
      @(negedge clk); underrun_clr = 1'b1;
      @(negedge clk); underrun_clr = 1'b0;
      chk("R9 flag cleared before test", underrun_flag, 0);
      wait_strobe();
      underrun_clr = 1'b1;
      @(negedge clk); underrun_clr = 1'b0;
      chk("R9 set wins over clear", underrun_flag, 1);
      @(negedge clk); underrun_clr = 1'b1;
      @(negedge clk); underrun_clr = 1'b0;
      chk("R9 flag cleared", underrun_flag, 0);

      // R10: reset in mid operation
      send(16'h7FFF);
      send(16'h2000);
      repeat (1200) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      chk("R10 flag", underrun_flag, 0);
      chk("R10 ready", smp_ready, 1);
      chk("R10 fine", pwm_fine, 0);
      rst = 1'b0;
      first_period("R10");
      measure_next(248, 0, "R10 stored sample dropped");

      repeat (5) @(negedge clk);
      finish_run();
   end
endmodule